// File: doc/BRIEF.md
# Memory ECC Error Capture and Reporting Registers

This block sits beside a memory controller's ECC checker and gives software a register view of memory errors. Each cycle the checker may present one access result: a valid strobe, single-bit and multi-bit error indications, the failing 64-bit data as two 32-bit words, the syndrome, and the access address with its upper extension. The block keeps two sticky detect flags and captures the details of the first error reported. It raises a level interrupt whenever an enabled flag is set.

Single-bit errors are not flagged one by one. They are counted against a programmable threshold, so software can ask to be told only once every N corrected errors. A mask can switch off detection of either error kind. Three injection registers let software corrupt outgoing write data and check bits on purpose, to exercise the error path end to end. Software reaches every register through a plain 32-bit word port: address, write enable and write data, with a combinational read return.

Top module: `mem_ecc_err_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Register word addresses: 0 detect, 1 disable, 2 interrupt enable, 3 single-bit management, 4 captured data high, 5 captured data low, 6 captured syndrome, 7 captured address, 8 captured address extension, 9 injection mask high, 10 injection mask low, 11 injection control.
- R2: An accepted multi-bit error (`chkValid` and `chkMulti` high, multi detection not disabled) sets detect bit 1, which stays set until software clears it.
- R3: The management register holds the threshold in bits 23:16 and the running single-bit count in bits 7:0, and a write loads both fields. Each accepted single-bit error adds one to the count. When the count reaches the threshold, detect bit 0 is set and the count returns to zero. With a threshold of zero, single-bit errors are ignored and the count stays unchanged.
- R4: Writing ones to the detect register clears the matching flags, and bits written as zero are untouched. If a flag is set in the same cycle as a write that clears it, the flag ends up set.
- R5: The capture registers load the data words, syndrome, address and extension of the error that sets a flag, but only while both detect flags are clear. Later errors leave the captured values unchanged.
- R6: When `busNarrow` is high, all 16 syndrome bits are captured. When it is low, only bits 7:0 are captured and bits 15:8 read as zero.
- R7: Bit 0 of the disable register blocks single-bit errors and bit 1 blocks multi-bit errors. A blocked error changes no flag, no count and no capture register.
- R8: `irq` is high exactly when some detect bit is set and its enable is set in the interrupt enable register (bit 0 for single-bit, bit 1 for multi-bit).
- R9: The injection control register holds the check-bit mask in bits 7:0 and the enable in bit 16. When the enable is set, the outgoing data high, data low and check bits equal the incoming write values XORed with their masks. When it is clear, they pass through unchanged.
- R10: The disable, interrupt enable, management and three injection registers read back what was written.
- R11: A result that shows a single-bit and a multi-bit error together counts as multi-bit only. It sets bit 1, and the single-bit count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| chkValid | input | 1 | Checker result valid |
| chkSingle | input | 1 | Single-bit (corrected) error |
| chkMulti | input | 1 | Multi-bit (uncorrectable) error |
| chkDataHi | input | 32 | Failing data, upper word |
| chkDataLo | input | 32 | Failing data, lower word |
| chkSyndrome | input | 16 | Syndrome from the checker |
| chkAddr | input | 32 | Failing address, low part |
| chkAddrExt | input | 4 | Failing address, upper extension |
| busNarrow | input | 1 | High selects 32-bit bus mode (16-bit syndrome) |
| wrDataHi | input | 32 | Write data upper word from controller |
| wrDataLo | input | 32 | Write data lower word from controller |
| wrCheck | input | 8 | Write check bits from controller |
| memDataHi | output | 32 | Write data upper word after injection |
| memDataLo | output | 32 | Write data lower word after injection |
| memCheck | output | 8 | Check bits after injection |
| irq | output | 1 | Error interrupt |

## Verification
The bench goes after the points where ordering matters. A second error after the first must not overwrite the capture, or the report would describe the wrong access. A clear that meets a new error in the same cycle must keep the flag, or an error would be lost without trace. An error showing both kinds must not also advance the single-bit count, or later threshold crossings would come early. It also walks the threshold across one, three and zero, where a counter that wraps late or fails to reset would flag on the wrong error, and it checks the wide-bus syndrome mask, since capturing stale upper bits there would make the reported syndrome wrong. Disabled error kinds and masked interrupts are checked at the detect register and the `irq` pin, so a mask that leaks shows up directly.

// File: rtl/eccrep_pkg.sv
package eccrep_pkg;

  localparam int REG_W      = 32;
  localparam int REG_ADDR_W = 4;
  localparam int NUM_FLAGS  = 2;
  localparam int FLAG_SBE   = 0;
  localparam int FLAG_MBE   = 1;
  localparam int THR_LSB    = 16;   // threshold field in management register
  localparam int INJ_EN_BIT = 16;   // injection enable in injection control

  typedef enum logic [REG_ADDR_W-1:0] {
    A_DETECT  = 4'd0,
    A_DISABLE = 4'd1,
    A_IRQEN   = 4'd2,
    A_SBEMGMT = 4'd3,
    A_CAPHI   = 4'd4,
    A_CAPLO   = 4'd5,
    A_CAPSYN  = 4'd6,
    A_CAPADR  = 4'd7,
    A_CAPEXT  = 4'd8,
    A_INJHI   = 4'd9,
    A_INJLO   = 4'd10,
    A_INJCTL  = 4'd11
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureLoad;
    logic capHold;
    logic injHiWe;
    logic injLoWe;
    logic injCtlWe;
  } dpStrobe_t;

endpackage

// File: rtl/eccrep_ctrl.sv
module eccrep_ctrl
  import eccrep_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [CNT_W-1:0]      wrLowField,
  input  logic [CNT_W-1:0]      wrThrField,
  input  logic                  chkValid,
  input  logic                  chkSingle,
  input  logic                  chkMulti,
  output dpStrobe_t             stb,
  output logic [REG_W-1:0]      ctrlRdData,
  output logic                  irq
);

  logic [NUM_FLAGS-1:0] detect, disMask, irqEn;
  logic [NUM_FLAGS-1:0] setVec, clrVec;
  logic [CNT_W-1:0]     thresh, count, cntNext;
  logic wrDetect, wrDisable, wrIrqEn, wrMgmt;
  logic mbeEvt, sbeEvt, sbeHit;

  always_comb begin
    wrDetect  = regWrEn && (regAddr == A_DETECT);
    wrDisable = regWrEn && (regAddr == A_DISABLE);
    wrIrqEn   = regWrEn && (regAddr == A_IRQEN);
    wrMgmt    = regWrEn && (regAddr == A_SBEMGMT);

    // multi-bit dominates a simultaneous single-bit indication
    mbeEvt  = chkValid && chkMulti && !disMask[FLAG_MBE];
    sbeEvt  = chkValid && chkSingle && !chkMulti && !disMask[FLAG_SBE]
              && (thresh != '0);
    cntNext = count + 1'b1;
    sbeHit  = sbeEvt && (cntNext >= thresh);

    setVec = '0;
    setVec[FLAG_SBE] = sbeHit;
    setVec[FLAG_MBE] = mbeEvt;
    clrVec = wrDetect ? wrLowField[NUM_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detect  <= '0;
      disMask <= '0;
      irqEn   <= '0;
      thresh  <= '0;
      count   <= '0;
    end else begin
      detect <= (detect & ~clrVec) | setVec;  // set wins over clear
      if (wrDisable) disMask <= wrLowField[NUM_FLAGS-1:0];
      if (wrIrqEn)   irqEn   <= wrLowField[NUM_FLAGS-1:0];
      if (wrMgmt) begin
        thresh <= wrThrField;
        count  <= wrLowField;
      end else if (sbeEvt) begin
        count <= sbeHit ? '0 : cntNext;
      end
    end
  end

  always_comb begin
    stb.captureLoad = (|setVec) && (detect == '0);
    stb.capHold     = |detect;
    stb.injHiWe     = regWrEn && (regAddr == A_INJHI);
    stb.injLoWe     = regWrEn && (regAddr == A_INJLO);
    stb.injCtlWe    = regWrEn && (regAddr == A_INJCTL);
    irq             = |(detect & irqEn);
  end

  always_comb begin
    ctrlRdData = '0;
    case (regAddr)
      A_DETECT:  ctrlRdData[NUM_FLAGS-1:0] = detect;
      A_DISABLE: ctrlRdData[NUM_FLAGS-1:0] = disMask;
      A_IRQEN:   ctrlRdData[NUM_FLAGS-1:0] = irqEn;
      A_SBEMGMT: begin
        ctrlRdData[CNT_W-1:0]         = count;
        ctrlRdData[THR_LSB +: CNT_W]  = thresh;
      end
      default:   ctrlRdData = '0;
    endcase
  end

  // R2: a multi-bit flag survives any cycle that does not clear it
  p_mbe_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    (detect[FLAG_MBE] && !(wrDetect && wrLowField[FLAG_MBE])) |=> detect[FLAG_MBE]);

  // R3: the count only moves on an accepted single-bit error or a write
  p_count_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!(chkValid && chkSingle) && !wrMgmt) |=> $stable(count));

  // R11: both error kinds together never advance the count
  p_multi_dominates_r11: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkSingle && chkMulti && !wrMgmt) |=> $stable(count));

endmodule

// File: rtl/eccrep_datapath.sv
module eccrep_datapath
  import eccrep_pkg::*;
#(
  parameter int SYN_W = 16,
  parameter int EXT_W = 4,
  parameter int CHK_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             stb,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]      regWrData,
  input  logic [REG_W-1:0]      chkDataHi,
  input  logic [REG_W-1:0]      chkDataLo,
  input  logic [SYN_W-1:0]      chkSyndrome,
  input  logic [REG_W-1:0]      chkAddr,
  input  logic [EXT_W-1:0]      chkAddrExt,
  input  logic                  busNarrow,
  input  logic [REG_W-1:0]      wrDataHi,
  input  logic [REG_W-1:0]      wrDataLo,
  input  logic [CHK_W-1:0]      wrCheck,
  output logic [REG_W-1:0]      memDataHi,
  output logic [REG_W-1:0]      memDataLo,
  output logic [CHK_W-1:0]      memCheck,
  output logic [REG_W-1:0]      dpRdData
);

  logic [REG_W-1:0] capHi, capLo, capAddr, injHi, injLo;
  logic [SYN_W-1:0] capSyn, synMasked;
  logic [EXT_W-1:0] capExt;
  logic [CHK_W-1:0] injChk;
  logic             injOn;

  // wide bus keeps only the low CHK_W syndrome bits
  for (genvar i = 0; i < SYN_W; i++) begin : g_synMask
    if (i < CHK_W) begin : g_low
      assign synMasked[i] = chkSyndrome[i];
    end else begin : g_high
      assign synMasked[i] = chkSyndrome[i] & busNarrow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capHi   <= '0;
      capLo   <= '0;
      capSyn  <= '0;
      capAddr <= '0;
      capExt  <= '0;
      injHi   <= '0;
      injLo   <= '0;
      injChk  <= '0;
      injOn   <= 1'b0;
    end else begin
      if (stb.captureLoad) begin
        capHi   <= chkDataHi;
        capLo   <= chkDataLo;
        capSyn  <= synMasked;
        capAddr <= chkAddr;
        capExt  <= chkAddrExt;
      end
      if (stb.injHiWe) injHi <= regWrData;
      if (stb.injLoWe) injLo <= regWrData;
      if (stb.injCtlWe) begin
        injChk <= regWrData[CHK_W-1:0];
        injOn  <= regWrData[INJ_EN_BIT];
      end
    end
  end

  always_comb begin
    memDataHi = injOn ? (wrDataHi ^ injHi) : wrDataHi;
    memDataLo = injOn ? (wrDataLo ^ injLo) : wrDataLo;
    memCheck  = injOn ? (wrCheck ^ injChk) : wrCheck;
  end

  always_comb begin
    dpRdData = '0;
    case (regAddr)
      A_CAPHI:  dpRdData = capHi;
      A_CAPLO:  dpRdData = capLo;
      A_CAPSYN: dpRdData = REG_W'(capSyn);
      A_CAPADR: dpRdData = capAddr;
      A_CAPEXT: dpRdData = REG_W'(capExt);
      A_INJHI:  dpRdData = injHi;
      A_INJLO:  dpRdData = injLo;
      A_INJCTL: begin
        dpRdData[CHK_W-1:0]  = injChk;
        dpRdData[INJ_EN_BIT] = injOn;
      end
      default:  dpRdData = '0;
    endcase
  end

  // R5: with a flag already set, the captured record does not move
  p_capture_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.capHold |=> ($stable(capHi) && $stable(capLo) && $stable(capAddr)
                     && $stable(capSyn) && $stable(capExt)));

  // R9: injection registers change only under their own write strobes
  p_inj_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.injHiWe || stb.injLoWe || stb.injCtlWe) |=>
      ($stable(injHi) && $stable(injLo) && $stable(injChk) && $stable(injOn)));

endmodule

// File: rtl/mem_ecc_err_ctrl.sv
module mem_ecc_err_ctrl
  import eccrep_pkg::*;
#(
  parameter int SYN_W = 16,
  parameter int EXT_W = 4,
  parameter int CHK_W = 8,
  parameter int CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic                  chkValid,
  input  logic                  chkSingle,
  input  logic                  chkMulti,
  input  logic [REG_W-1:0]      chkDataHi,
  input  logic [REG_W-1:0]      chkDataLo,
  input  logic [SYN_W-1:0]      chkSyndrome,
  input  logic [REG_W-1:0]      chkAddr,
  input  logic [EXT_W-1:0]      chkAddrExt,
  input  logic                  busNarrow,
  input  logic [REG_W-1:0]      wrDataHi,
  input  logic [REG_W-1:0]      wrDataLo,
  input  logic [CHK_W-1:0]      wrCheck,
  output logic [REG_W-1:0]      memDataHi,
  output logic [REG_W-1:0]      memDataLo,
  output logic [CHK_W-1:0]      memCheck,
  output logic                  irq
);

  dpStrobe_t        stb;
  logic [REG_W-1:0] ctrlRdData, dpRdData;

  eccrep_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .wrLowField (regWrData[CNT_W-1:0]),
    .wrThrField (regWrData[THR_LSB +: CNT_W]),
    .chkValid   (chkValid),
    .chkSingle  (chkSingle),
    .chkMulti   (chkMulti),
    .stb        (stb),
    .ctrlRdData (ctrlRdData),
    .irq        (irq)
  );

  eccrep_datapath #(.SYN_W(SYN_W), .EXT_W(EXT_W), .CHK_W(CHK_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .chkDataHi   (chkDataHi),
    .chkDataLo   (chkDataLo),
    .chkSyndrome (chkSyndrome),
    .chkAddr     (chkAddr),
    .chkAddrExt  (chkAddrExt),
    .busNarrow   (busNarrow),
    .wrDataHi    (wrDataHi),
    .wrDataLo    (wrDataLo),
    .wrCheck     (wrCheck),
    .memDataHi   (memDataHi),
    .memDataLo   (memDataLo),
    .memCheck    (memCheck),
    .dpRdData    (dpRdData)
  );

  assign regRdData = ctrlRdData | dpRdData;

  // R8: the interrupt only rises after a checker result or a register write
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(chkValid) || $past(regWrEn)));

endmodule

// File: tb/mem_ecc_err_ctrl_tb.sv
module mem_ecc_err_ctrl_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        chkValid = 1'b0, chkSingle = 1'b0, chkMulti = 1'b0;
  logic [31:0] chkDataHi = '0, chkDataLo = '0, chkAddr = '0;
  logic [15:0] chkSyndrome = '0;
  logic [3:0]  chkAddrExt = '0;
  logic        busNarrow = 1'b0;
  logic [31:0] wrDataHi = '0, wrDataLo = '0;
  logic [7:0]  wrCheck = '0;
  logic [31:0] memDataHi, memDataLo;
  logic [7:0]  memCheck;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  mem_ecc_err_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .chkValid(chkValid),
    .chkSingle(chkSingle), .chkMulti(chkMulti), .chkDataHi(chkDataHi),
    .chkDataLo(chkDataLo), .chkSyndrome(chkSyndrome), .chkAddr(chkAddr),
    .chkAddrExt(chkAddrExt), .busNarrow(busNarrow), .wrDataHi(wrDataHi),
    .wrDataLo(wrDataLo), .wrCheck(wrCheck), .memDataHi(memDataHi),
    .memDataLo(memDataLo), .memCheck(memCheck), .irq(irq)
  );

  typedef struct packed {
    logic        s;
    logic        m;
    logic        narrow;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [15:0] syn;
    logic [31:0] addr;
    logic [3:0]  ext;
    logic [1:0]  expDet;
    logic [15:0] expSyn;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{1'b1, 1'b0, 1'b0, 32'hDEADBEEF, 32'h01234567, 16'hABCD, 32'h10000040, 4'h3, 2'b01, 16'h00CD},
    '{1'b0, 1'b1, 1'b1, 32'hCAFEF00D, 32'h89ABCDEF, 16'h1234, 32'h20000080, 4'hA, 2'b10, 16'h1234},
    '{1'b1, 1'b1, 1'b0, 32'h11112222, 32'h33334444, 16'hFF01, 32'h00000FF8, 4'h0, 2'b10, 16'h0001},
    '{1'b0, 1'b0, 1'b1, 32'h55555555, 32'hAAAAAAAA, 16'h0F0F, 32'h30000000, 4'h1, 2'b00, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 32'h0BADC0DE, 32'hFEEDFACE, 16'h8001, 32'h40001230, 4'hF, 2'b01, 16'h8001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic evt(input logic s, input logic m, input logic nar,
                     input logic [31:0] hi, input logic [31:0] lo,
                     input logic [15:0] syn, input logic [31:0] adr,
                     input logic [3:0] ext);
    chkValid = 1'b1; chkSingle = s; chkMulti = m; busNarrow = nar;
    chkDataHi = hi; chkDataLo = lo; chkSyndrome = syn; chkAddr = adr; chkAddrExt = ext;
    @(posedge clk); @(negedge clk);
    chkValid = 1'b0; chkSingle = 1'b0; chkMulti = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    regRead(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state of every register and the interrupt
    for (int a = 0; a < 12; a++) expectReg("R1 reset", 4'(a), 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R10: configuration readback
    regWrite(4'd2, 32'h3);
    regWrite(4'd3, 32'h00010000);
    expectReg("R10 irqen", 4'd2, 32'h3);
    expectReg("R10 mgmt", 4'd3, 32'h00010000);

    // vector table with threshold one: R2 R3 R5 R6 R8 R11
    for (int i = 0; i < 5; i++) begin
      regWrite(4'd0, 32'hFFFFFFFF);
      evt(VEC[i].s, VEC[i].m, VEC[i].narrow, VEC[i].hi, VEC[i].lo,
          VEC[i].syn, VEC[i].addr, VEC[i].ext);
      expectReg("R2/R3/R11 detect", 4'd0, {30'b0, VEC[i].expDet});
      check("R8 irq", {31'b0, irq}, {31'b0, |VEC[i].expDet});
      expectReg("R11 count", 4'd3, 32'h00010000);
      if (VEC[i].expDet != 2'b00) begin
        expectReg("R5 capHi", 4'd4, VEC[i].hi);
        expectReg("R5 capLo", 4'd5, VEC[i].lo);
        expectReg("R6 capSyn", 4'd6, {16'b0, VEC[i].expSyn});
        expectReg("R5 capAddr", 4'd7, VEC[i].addr);
        expectReg("R5 capExt", 4'd8, {28'b0, VEC[i].ext});
      end
    end

    // R5: first error kept, second ignored
    regWrite(4'd0, 32'hFFFFFFFF);
    evt(1'b0, 1'b1, 1'b1, 32'hAAAA0001, 32'hBBBB0002, 16'h0101, 32'h00001000, 4'h2);
    evt(1'b1, 1'b0, 1'b1, 32'hCCCC0003, 32'hDDDD0004, 16'h0202, 32'h00002000, 4'h4);
    expectReg("R5 both flags", 4'd0, 32'h3);
    expectReg("R5 first hi kept", 4'd4, 32'hAAAA0001);
    expectReg("R5 first addr kept", 4'd7, 32'h00001000);

    // R4: partial write-one-to-clear
    regWrite(4'd0, 32'h1);
    expectReg("R4 clear bit0 only", 4'd0, 32'h2);
    regWrite(4'd0, 32'h2);
    expectReg("R4 clear bit1", 4'd0, 32'h0);

    // R4: set wins over a simultaneous clear
    regAddr = 4'd0; regWrData = 32'hFFFFFFFF; regWrEn = 1'b1;
    chkValid = 1'b1; chkMulti = 1'b1; chkSingle = 1'b0;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; chkValid = 1'b0; chkMulti = 1'b0;
    expectReg("R4 set beats clear", 4'd0, 32'h2);

    // R3: threshold of three
    regWrite(4'd3, 32'h00030000);
    regWrite(4'd0, 32'hFFFFFFFF);
    evt(1'b1, 1'b0, 1'b0, 32'h1, 32'h1, 16'h1, 32'h100, 4'h1);
    expectReg("R3 count one", 4'd3, 32'h00030001);
    evt(1'b1, 1'b0, 1'b0, 32'h2, 32'h2, 16'h2, 32'h200, 4'h2);
    expectReg("R3 no flag below threshold", 4'd0, 32'h0);
    expectReg("R3 count two", 4'd3, 32'h00030002);
    evt(1'b1, 1'b0, 1'b0, 32'h3, 32'h3, 16'h3, 32'h300, 4'h3);
    expectReg("R3 flag at threshold", 4'd0, 32'h1);
    expectReg("R3 count reset", 4'd3, 32'h00030000);
    expectReg("R5 capture at threshold", 4'd7, 32'h300);

    // R3: threshold zero ignores single-bit errors
    regWrite(4'd3, 32'h00000000);
    regWrite(4'd0, 32'hFFFFFFFF);
    evt(1'b1, 1'b0, 1'b0, 32'h4, 32'h4, 16'h4, 32'h400, 4'h4);
    expectReg("R3 zero threshold no flag", 4'd0, 32'h0);
    expectReg("R3 zero threshold count", 4'd3, 32'h0);

    // R7: disable mask
    regWrite(4'd3, 32'h00010000);
    regWrite(4'd1, 32'h3);
    expectReg("R10 disable", 4'd1, 32'h3);
    evt(1'b0, 1'b1, 1'b0, 32'h5, 32'h5, 16'h5, 32'h500, 4'h5);
    evt(1'b1, 1'b0, 1'b0, 32'h6, 32'h6, 16'h6, 32'h600, 4'h6);
    expectReg("R7 masked detect", 4'd0, 32'h0);
    expectReg("R7 masked count", 4'd3, 32'h00010000);
    expectReg("R7 masked capture", 4'd7, 32'h300);
    check("R7 irq", {31'b0, irq}, 32'h0);
    regWrite(4'd1, 32'h0);

    // R8: interrupt enable per flag
    regWrite(4'd2, 32'h1);
    evt(1'b0, 1'b1, 1'b0, 32'h7, 32'h7, 16'h7, 32'h700, 4'h7);
    expectReg("R8 detect", 4'd0, 32'h2);
    check("R8 masked irq", {31'b0, irq}, 32'h0);
    regWrite(4'd2, 32'h2);
    check("R8 enabled irq", {31'b0, irq}, 32'h1);
    regWrite(4'd0, 32'hFFFFFFFF);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);

    // R9: injection
    wrDataHi = 32'h12345678; wrDataLo = 32'h9ABCDEF0; wrCheck = 8'h3C;
    regWrite(4'd9, 32'h0000FFFF);
    regWrite(4'd10, 32'h80000001);
    regWrite(4'd11, 32'h0000005A);
    #1;
    check("R9 pass hi", memDataHi, 32'h12345678);
    check("R9 pass lo", memDataLo, 32'h9ABCDEF0);
    check("R9 pass chk", {24'b0, memCheck}, 32'h3C);
    regWrite(4'd11, 32'h0001005A);
    #1;
    check("R9 inject hi", memDataHi, 32'h1234A987);
    check("R9 inject lo", memDataLo, 32'h1ABCDEF1);
    check("R9 inject chk", {24'b0, memCheck}, 32'h66);
    expectReg("R10 injhi", 4'd9, 32'h0000FFFF);
    expectReg("R10 injlo", 4'd10, 32'h80000001);
    expectReg("R10 injctl", 4'd11, 32'h0001005A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule